// File: doc/BRIEF.md
# Pipeline Hazard and Branch Control

This block steers a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back) that runs add, sub, and, or, addi, ld, sd, beq and nop on 64-bit registers. The datapath, register file, ALU and memories sit outside it. Each cycle it reads the decode-stage instruction word, the register indices and control bits held in the execute, memory and write-back pipeline registers, and the branch compare result formed in execute. From these it returns operand forwarding selects, the freeze and bubble controls for a load-use hazard, the flush controls for the younger stages, and the fetch address, which it holds in its own PC register.

Every beq is treated as taken. Once the branch sits in decode, fetch jumps to its target and the one instruction fetched behind it is squashed. If execute then finds the operands unequal, the two younger stages are flushed and fetch restarts right after the branch. That costs two cycles. A loaded register needed by the very next instruction costs a one-cycle freeze. After the freeze, the value arrives through the write-back forwarding path. Loads and stores move aligned 64-bit doublewords, so the datapath must supply data addresses that are multiples of 8.

Top module: `hzc_ctrl`

## Requirements
- R1: After reset is released with every valid input low, `fetch_pc` equals RESET_PC, all stall, bubble and flush outputs are 0, and both forwarding selects are 0.
- R2: For each ALU operand, the select is 2'b10 when the memory-stage instruction writes that source register. Otherwise it is 2'b01 when the write-back-stage instruction writes it. Otherwise it is 2'b00, meaning the register file. The memory stage wins when both stages match.
- R3: No forwarding comes from a stage whose valid is low, whose write enable is low, or whose destination is x0. A source index of x0 always gives select 2'b00.
- R4: A load-use hazard occurs when a valid ld in execute writes a non-zero destination that a valid decode instruction reads. During a load-use hazard, `stall_pc`, `stall_ifid` and `bubble_idex` are 1 for that cycle, and `fetch_pc` holds its value.
- R5: The decode instruction counts as reading only the sources its opcode uses. Opcode bits [6:0] decode as 0110011 (add/sub/and/or) reading rs1 [19:15] and rs2 [24:20]; 0100011 (sd) and 1100011 (beq) also read both. 0010011 (addi, including nop = addi x0,x0,0) and 0000011 (ld) read only rs1. Any other opcode reads none.
- R6: A valid beq in decode with no stall and no misprediction sets `flush_ifid` and loads `fetch_pc` with the decode PC plus the sign-extended B-type offset. The offset is 13 bits: bit 12 = instr[31], bit 11 = instr[7], bits 10:5 = instr[30:25], bits 4:1 = instr[11:8], bit 0 = 0.
- R7: A valid branch in execute with its compare result low is a misprediction. It sets `flush_ifid` and `flush_idex`, loads `fetch_pc` with the execute PC plus 4, and overrides any prediction made in the same cycle.
- R8: When a misprediction and a load-use hazard occur together, the flush wins: stall and bubble stay 0.
- R9: With no stall, prediction or misprediction, `fetch_pc` advances by 4 each cycle.
- R10: A branch in execute whose compare result is high causes no flush.
- R11: A beq in decode that is frozen by a load-use hazard is not predicted that cycle: `flush_ifid` stays 0 and `fetch_pc` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a live instruction |
| id_instr | input | 32 | Decode stage instruction word |
| id_pc | input | XLEN | Address of the decode instruction |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_rs1 | input | 5 | Execute first source index |
| ex_rs2 | input | 5 | Execute second source index |
| ex_rd | input | 5 | Execute destination index |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is ld |
| ex_is_branch | input | 1 | Execute instruction is beq |
| ex_br_eq | input | 1 | Forwarded operands compared equal |
| ex_pc | input | XLEN | Address of the execute instruction |
| mem_valid | input | 1 | Memory stage holds a live instruction |
| mem_rd | input | 5 | Memory stage destination index |
| mem_wen | input | 1 | Memory stage writes a register |
| wb_valid | input | 1 | Write-back stage holds a live instruction |
| wb_rd | input | 5 | Write-back destination index |
| wb_wen | input | 1 | Write-back writes a register |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| stall_pc | output | 1 | Freeze the PC |
| stall_ifid | output | 1 | Freeze the fetch/decode register |
| bubble_idex | output | 1 | Load an all-zero control word into decode/execute |
| flush_ifid | output | 1 | Squash the fetch/decode register |
| flush_idex | output | 1 | Squash the decode/execute register |
| fetch_pc | output | XLEN | Registered fetch address |

## Verification
The bench builds the block with XLEN = 64 and RESET_PC = 0x1000. The non-zero reset address makes a stuck or wrongly reset PC show up at once. The full 64-bit width lets a backward beq offset sign-extend across the whole word. It also lets the bench tell apart the predicted target, the recovery address (execute PC + 4) and the plain sequential address, so each path through the next-PC choice yields a distinct expected value.

// File: rtl/hzc_pkg.sv
`timescale 1ns/1ps
package hzc_pkg;
  localparam int REG_AW = 5;
  localparam int INSTR_W = 32;

  localparam logic [6:0] OPC_ALU_RR = 7'b0110011;
  localparam logic [6:0] OPC_ALU_RI = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  typedef struct packed {
    logic              valid;
    logic              wen;
    logic [REG_AW-1:0] rd;
  } wr_port_t;
endpackage

// File: rtl/hzc_id_decode.sv
`timescale 1ns/1ps
module hzc_id_decode
  import hzc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [REG_AW-1:0]  rs1,
  output logic [REG_AW-1:0]  rs2,
  output logic               use_rs1,
  output logic               use_rs2,
  output logic               is_branch,
  output logic [XLEN-1:0]    br_off
);
  localparam int OFF_W = 13;

  logic [6:0]       opc;
  logic [OFF_W-1:0] off_raw;
  logic [2:0]       unused_funct3;

  assign opc           = instr[6:0];
  assign rs1           = instr[19:15];
  assign rs2           = instr[24:20];
  assign unused_funct3 = instr[14:12];

  always_comb begin
    use_rs1   = 1'b0;
    use_rs2   = 1'b0;
    is_branch = 1'b0;
    unique case (opc)
      OPC_ALU_RR: begin use_rs1 = 1'b1; use_rs2 = 1'b1; end
      OPC_STORE:  begin use_rs1 = 1'b1; use_rs2 = 1'b1; end
      OPC_BRANCH: begin use_rs1 = 1'b1; use_rs2 = 1'b1; is_branch = 1'b1; end
      OPC_ALU_RI: use_rs1 = 1'b1;
      OPC_LOAD:   use_rs1 = 1'b1;
      default: ;
    endcase
  end

  assign off_raw = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
  assign br_off  = {{(XLEN-OFF_W){off_raw[OFF_W-1]}}, off_raw};
endmodule

// File: rtl/hzc_fwd_sel.sv
`timescale 1ns/1ps
module hzc_fwd_sel
  import hzc_pkg::*;
(
  input  logic [REG_AW-1:0] src,
  input  wr_port_t          mem_wr,
  input  wr_port_t          wb_wr,
  output fwd_sel_e          sel
);
  logic mem_hit;
  logic wb_hit;

  assign mem_hit = mem_wr.valid && mem_wr.wen && (mem_wr.rd != '0) && (mem_wr.rd == src);
  assign wb_hit  = wb_wr.valid  && wb_wr.wen  && (wb_wr.rd  != '0) && (wb_wr.rd  == src);

  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hzc_hazard.sv
`timescale 1ns/1ps
module hzc_hazard
  import hzc_pkg::*;
(
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use_rs1,
  input  logic              id_use_rs2,
  input  logic              id_is_branch,
  input  logic              ex_valid,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic              ex_is_branch,
  input  logic              ex_br_eq,
  input  logic [REG_AW-1:0] ex_rd,
  output logic              hold,
  output logic              bubble,
  output logic              mispredict,
  output logic              predict,
  output logic              flush_young,
  output logic              flush_mid
);
  logic load_pending;
  logic src_hit;
  logic load_use;

  assign load_pending = ex_valid && ex_is_load && ex_wen && (ex_rd != '0);
  assign src_hit      = (id_use_rs1 && (id_rs1 == ex_rd)) ||
                        (id_use_rs2 && (id_rs2 == ex_rd));
  assign load_use     = load_pending && id_valid && src_hit;

  assign mispredict   = ex_valid && ex_is_branch && !ex_br_eq;
  assign hold         = load_use && !mispredict;
  assign bubble       = hold;
  assign predict      = id_valid && id_is_branch && !mispredict && !load_use;
  assign flush_young  = mispredict || predict;
  assign flush_mid    = mispredict;
endmodule

// File: rtl/hzc_pc_reg.sv
`timescale 1ns/1ps
module hzc_pc_reg #(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            mispredict,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            predict,
  input  logic [XLEN-1:0] id_pc,
  input  logic [XLEN-1:0] br_off,
  output logic [XLEN-1:0] pc_q
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_d;

  always_comb begin
    if (mispredict)   pc_d = ex_pc + STEP;
    else if (hold)    pc_d = pc_q;
    else if (predict) pc_d = id_pc + br_off;
    else              pc_d = pc_q + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_d;
  end
endmodule

// File: rtl/hzc_ctrl.sv
`timescale 1ns/1ps
module hzc_ctrl
  import hzc_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               id_valid,
  input  logic [31:0]        id_instr,
  input  logic [XLEN-1:0]    id_pc,
  input  logic               ex_valid,
  input  logic [4:0]         ex_rs1,
  input  logic [4:0]         ex_rs2,
  input  logic [4:0]         ex_rd,
  input  logic               ex_wen,
  input  logic               ex_is_load,
  input  logic               ex_is_branch,
  input  logic               ex_br_eq,
  input  logic [XLEN-1:0]    ex_pc,
  input  logic               mem_valid,
  input  logic [4:0]         mem_rd,
  input  logic               mem_wen,
  input  logic               wb_valid,
  input  logic [4:0]         wb_rd,
  input  logic               wb_wen,
  output logic [1:0]         fwd_a,
  output logic [1:0]         fwd_b,
  output logic               stall_pc,
  output logic               stall_ifid,
  output logic               bubble_idex,
  output logic               flush_ifid,
  output logic               flush_idex,
  output logic [XLEN-1:0]    fetch_pc
);
  localparam int N_OPS = 2;

  logic [REG_AW-1:0] id_rs1, id_rs2;
  logic              id_use_rs1, id_use_rs2, id_is_branch;
  logic [XLEN-1:0]   br_off;
  logic              hold, bubble, mispredict, predict, flush_young, flush_mid;

  wr_port_t          mem_wr, wb_wr;
  logic [REG_AW-1:0] ex_src [N_OPS];
  fwd_sel_e          op_sel [N_OPS];

  hzc_id_decode #(.XLEN(XLEN)) u_dec (
    .instr     (id_instr),
    .rs1       (id_rs1),
    .rs2       (id_rs2),
    .use_rs1   (id_use_rs1),
    .use_rs2   (id_use_rs2),
    .is_branch (id_is_branch),
    .br_off    (br_off)
  );

  assign mem_wr    = '{valid: mem_valid, wen: mem_wen, rd: mem_rd};
  assign wb_wr     = '{valid: wb_valid,  wen: wb_wen,  rd: wb_rd};
  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    hzc_fwd_sel u_fwd (
      .src    (ex_src[g]),
      .mem_wr (mem_wr),
      .wb_wr  (wb_wr),
      .sel    (op_sel[g])
    );
  end

  hzc_hazard u_haz (
    .id_valid     (id_valid),
    .id_rs1       (id_rs1),
    .id_rs2       (id_rs2),
    .id_use_rs1   (id_use_rs1),
    .id_use_rs2   (id_use_rs2),
    .id_is_branch (id_is_branch),
    .ex_valid     (ex_valid),
    .ex_wen       (ex_wen),
    .ex_is_load   (ex_is_load),
    .ex_is_branch (ex_is_branch),
    .ex_br_eq     (ex_br_eq),
    .ex_rd        (ex_rd),
    .hold         (hold),
    .bubble       (bubble),
    .mispredict   (mispredict),
    .predict      (predict),
    .flush_young  (flush_young),
    .flush_mid    (flush_mid)
  );

  hzc_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .mispredict (mispredict),
    .ex_pc      (ex_pc),
    .predict    (predict),
    .id_pc      (id_pc),
    .br_off     (br_off),
    .pc_q       (fetch_pc)
  );

  assign fwd_a       = op_sel[0];
  assign fwd_b       = op_sel[1];
  assign stall_pc    = hold;
  assign stall_ifid  = hold;
  assign bubble_idex = bubble;
  assign flush_ifid  = flush_young;
  assign flush_idex  = flush_mid;
endmodule

// File: rtl/hzc_ctrl_checker.sv
`timescale 1ns/1ps
module hzc_ctrl_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            ex_valid,
  input logic [4:0]      ex_rs1,
  input logic [4:0]      ex_rs2,
  input logic            ex_is_branch,
  input logic            ex_br_eq,
  input logic [XLEN-1:0] ex_pc,
  input logic            mem_valid,
  input logic [4:0]      mem_rd,
  input logic            mem_wen,
  input logic [1:0]      fwd_a,
  input logic [1:0]      fwd_b,
  input logic            stall_pc,
  input logic            stall_ifid,
  input logic            bubble_idex,
  input logic            flush_ifid,
  input logic            flush_idex,
  input logic [XLEN-1:0] fetch_pc
);
  localparam logic [XLEN-1:0] FOUR = XLEN'(4);

  p_mem_first_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_wen && mem_rd != 5'd0 && mem_rd == ex_rs1) |-> fwd_a == 2'b10);

  p_zero_src_r3: assert property (@(posedge clk) disable iff (rst)
    (ex_rs2 == 5'd0) |-> fwd_b == 2'b00);

  p_stall_group_r4: assert property (@(posedge clk) disable iff (rst)
    stall_pc |-> (stall_ifid && bubble_idex));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    stall_pc |=> fetch_pc == $past(fetch_pc));

  p_recover_pc_r7: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_is_branch && !ex_br_eq) |=> fetch_pc == $past(ex_pc) + FOUR);

  p_flush_wins_r8: assert property (@(posedge clk) disable iff (rst)
    flush_idex |-> (!stall_pc && !bubble_idex && flush_ifid));

  p_sequential_r9: assert property (@(posedge clk) disable iff (rst)
    (!stall_pc && !flush_ifid && !flush_idex) |=> fetch_pc == $past(fetch_pc) + FOUR);

  p_taken_ok_r10: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_is_branch && ex_br_eq) |-> !flush_idex);
endmodule

bind hzc_ctrl hzc_ctrl_checker #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ex_valid     (ex_valid),
  .ex_rs1       (ex_rs1),
  .ex_rs2       (ex_rs2),
  .ex_is_branch (ex_is_branch),
  .ex_br_eq     (ex_br_eq),
  .ex_pc        (ex_pc),
  .mem_valid    (mem_valid),
  .mem_rd       (mem_rd),
  .mem_wen      (mem_wen),
  .fwd_a        (fwd_a),
  .fwd_b        (fwd_b),
  .stall_pc     (stall_pc),
  .stall_ifid   (stall_ifid),
  .bubble_idex  (bubble_idex),
  .flush_ifid   (flush_ifid),
  .flush_idex   (flush_idex),
  .fetch_pc     (fetch_pc)
);

// File: tb/hzc_ctrl_bench.sv
`timescale 1ns/1ps
module hzc_ctrl_bench;
  localparam int          XLEN = 64;
  localparam logic [63:0] RPC  = 64'h1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  typedef struct {
    logic idv; logic [31:0] ins; logic [63:0] idpc;
    logic exv; logic [4:0] exs1, exs2, exrd;
    logic exw, exld, exbr, exeq; logic [63:0] expc;
    logic mv; logic [4:0] mrd; logic mw;
    logic wv; logic [4:0] wrd; logic ww;
  } stim_t;

  typedef struct {
    logic [1:0] fa, fb; logic st, fif, fex; logic [63:0] npc; string req;
  } exp_t;

  logic        id_valid, ex_valid, ex_wen, ex_is_load, ex_is_branch, ex_br_eq;
  logic        mem_valid, mem_wen, wb_valid, wb_wen;
  logic [31:0] id_instr;
  logic [63:0] id_pc, ex_pc, fetch_pc;
  logic [4:0]  ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic [1:0]  fwd_a, fwd_b;
  logic        stall_pc, stall_ifid, bubble_idex, flush_ifid, flush_idex;

  hzc_ctrl #(.XLEN(XLEN), .RESET_PC(RPC)) u_hzc_ctrl (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_instr(id_instr), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
    .ex_wen(ex_wen), .ex_is_load(ex_is_load), .ex_is_branch(ex_is_branch),
    .ex_br_eq(ex_br_eq), .ex_pc(ex_pc), .mem_valid(mem_valid), .mem_rd(mem_rd),
    .mem_wen(mem_wen), .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall_pc(stall_pc), .stall_ifid(stall_ifid),
    .bubble_idex(bubble_idex), .flush_ifid(flush_ifid), .flush_idex(flush_idex),
    .fetch_pc(fetch_pc)
  );

  int   total = 0;
  int   bad   = 0;
  exp_t sb_q[$];

  function automatic logic [31:0] enc_rr(input logic [4:0] rd, rs1, rs2);
    return {7'b0, rs2, rs1, 3'b000, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_ri(input logic [6:0] opc, input logic [2:0] f3,
                                         input logic [4:0] rd, rs1, input logic [11:0] imm);
    return {imm, rs1, f3, rd, opc};
  endfunction
  function automatic logic [31:0] enc_sd(input logic [4:0] rs2, rs1);
    return {7'b0, rs2, rs1, 3'b011, 5'b0, 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_beq(input logic [4:0] rs1, rs2, input logic [12:0] off);
    return {off[12], off[10:5], rs2, rs1, 3'b000, off[4:1], off[11], 7'b1100011};
  endfunction

  function automatic stim_t idle();
    stim_t s;
    s.idv = 0; s.ins = 32'h0; s.idpc = 64'h0;
    s.exv = 0; s.exs1 = 0; s.exs2 = 0; s.exrd = 0;
    s.exw = 0; s.exld = 0; s.exbr = 0; s.exeq = 0; s.expc = 64'h0;
    s.mv = 0; s.mrd = 0; s.mw = 0; s.wv = 0; s.wrd = 0; s.ww = 0;
    return s;
  endfunction

  task automatic apply(input stim_t s);
    id_valid = s.idv; id_instr = s.ins; id_pc = s.idpc;
    ex_valid = s.exv; ex_rs1 = s.exs1; ex_rs2 = s.exs2; ex_rd = s.exrd;
    ex_wen = s.exw; ex_is_load = s.exld; ex_is_branch = s.exbr; ex_br_eq = s.exeq;
    ex_pc = s.expc; mem_valid = s.mv; mem_rd = s.mrd; mem_wen = s.mw;
    wb_valid = s.wv; wb_rd = s.wrd; wb_wen = s.ww;
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic go(input stim_t s, input logic [1:0] fa, fb, input logic st, fif, fex,
                    input logic [63:0] npc, input string req);
    exp_t e;
    @(negedge clk);
    apply(s);
    e.fa = fa; e.fb = fb; e.st = st; e.fif = fif; e.fex = fex; e.npc = npc; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: pops one expectation per edge, after the PC register has moved
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, "fwd_a", 64'(fwd_a), 64'(e.fa));
        chk(e.req, "fwd_b", 64'(fwd_b), 64'(e.fb));
        chk(e.req, "stall_pc", 64'(stall_pc), 64'(e.st));
        chk(e.req, "stall_ifid", 64'(stall_ifid), 64'(e.st));
        chk(e.req, "bubble_idex", 64'(bubble_idex), 64'(e.st));
        chk(e.req, "flush_ifid", 64'(flush_ifid), 64'(e.fif));
        chk(e.req, "flush_idex", 64'(flush_idex), 64'(e.fex));
        chk(e.req, "fetch_pc", fetch_pc, e.npc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    stim_t s;
    apply(idle());
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1", "fetch_pc", fetch_pc, RPC);
    chk("R1", "stall_pc", 64'(stall_pc), 0);
    chk("R1", "flush_ifid", 64'(flush_ifid), 0);
    chk("R1", "flush_idex", 64'(flush_idex), 0);
    chk("R1", "fwd_a", 64'(fwd_a), 0);

    // R9: idle, sequential fetch (one unchecked edge already passed -> 0x1004)
    go(idle(), 2'b00, 2'b00, 0, 0, 0, 64'h1008, "R9");
    go(idle(), 2'b00, 2'b00, 0, 0, 0, 64'h100C, "R9");

    // R2: memory stage beats write-back on A; B from write-back
    s = idle(); s.idv = 1; s.ins = enc_rr(5'd1, 5'd2, 5'd3);
    s.exv = 1; s.exs1 = 5'd3; s.exs2 = 5'd4;
    s.mv = 1; s.mw = 1; s.mrd = 5'd3; s.wv = 1; s.ww = 1; s.wrd = 5'd3;
    go(s, 2'b10, 2'b00, 0, 0, 0, 64'h1010, "R2");
    s.wrd = 5'd4;
    go(s, 2'b10, 2'b01, 0, 0, 0, 64'h1014, "R2");

    // R3: x0 destination, write enable low, x0 source
    s = idle(); s.exv = 1; s.exs1 = 5'd5; s.exs2 = 5'd0;
    s.mv = 1; s.mw = 1; s.mrd = 5'd0; s.wv = 1; s.ww = 0; s.wrd = 5'd5;
    go(s, 2'b00, 2'b00, 0, 0, 0, 64'h1018, "R3");
    // R3: invalid memory stage ignored, write-back used
    s = idle(); s.exv = 1; s.exs1 = 5'd6;
    s.mv = 0; s.mw = 1; s.mrd = 5'd6; s.wv = 1; s.ww = 1; s.wrd = 5'd6;
    go(s, 2'b01, 2'b00, 0, 0, 0, 64'h101C, "R3");

    // R4: load-use on rs1, then on rs2 (sd)
    s = idle(); s.exv = 1; s.exld = 1; s.exw = 1; s.exrd = 5'd7;
    s.idv = 1; s.ins = enc_rr(5'd1, 5'd7, 5'd2);
    go(s, 2'b00, 2'b00, 1, 0, 0, 64'h101C, "R4");
    s.ins = enc_sd(5'd7, 5'd2);
    go(s, 2'b00, 2'b00, 1, 0, 0, 64'h101C, "R4");
    // R4: decode not valid -> no stall
    s.idv = 0; s.ins = enc_rr(5'd1, 5'd7, 5'd2);
    go(s, 2'b00, 2'b00, 0, 0, 0, 64'h1020, "R4");

    // R5: addi with rs2 field = 7 (immediate bits) must not stall
    s = idle(); s.exv = 1; s.exld = 1; s.exw = 1; s.exrd = 5'd7;
    s.idv = 1; s.ins = enc_ri(7'b0010011, 3'b000, 5'd1, 5'd2, 12'd7);
    go(s, 2'b00, 2'b00, 0, 0, 0, 64'h1024, "R5");
    // R5: ld with rs2 field = 8 against load to x8 must not stall
    s.exrd = 5'd8; s.ins = enc_ri(7'b0000011, 3'b011, 5'd1, 5'd2, 12'd8);
    go(s, 2'b00, 2'b00, 0, 0, 0, 64'h1028, "R5");
    // R5: nop after a load to x0 must not stall
    s.exrd = 5'd0; s.ins = enc_ri(7'b0010011, 3'b000, 5'd0, 5'd0, 12'd0);
    go(s, 2'b00, 2'b00, 0, 0, 0, 64'h102C, "R5");

    // R6: predicted taken, forward then backward offset
    s = idle(); s.idv = 1; s.idpc = 64'h102C; s.ins = enc_beq(5'd1, 5'd2, 13'h0040);
    go(s, 2'b00, 2'b00, 0, 1, 0, 64'h106C, "R6");
    s.idpc = 64'h106C; s.ins = enc_beq(5'd1, 5'd2, 13'h1FF0);
    go(s, 2'b00, 2'b00, 0, 1, 0, 64'h105C, "R6");

    // R10: resolved taken, no flush
    s = idle(); s.exv = 1; s.exbr = 1; s.exeq = 1; s.expc = 64'h106C;
    go(s, 2'b00, 2'b00, 0, 0, 0, 64'h1060, "R10");

    // R7: misprediction overrides a beq in decode
    s = idle(); s.exv = 1; s.exbr = 1; s.exeq = 0; s.expc = 64'h106C;
    s.idv = 1; s.idpc = 64'h1060; s.ins = enc_beq(5'd1, 5'd2, 13'h0040);
    go(s, 2'b00, 2'b00, 0, 1, 1, 64'h1070, "R7");

    // R8: flush beats a simultaneous load-use
    s = idle(); s.exv = 1; s.exbr = 1; s.exeq = 0; s.expc = 64'h2000;
    s.exld = 1; s.exw = 1; s.exrd = 5'd7;
    s.idv = 1; s.ins = enc_rr(5'd1, 5'd7, 5'd2);
    go(s, 2'b00, 2'b00, 0, 1, 1, 64'h2004, "R8");

    // R11: beq frozen by load-use is not predicted
    s = idle(); s.exv = 1; s.exld = 1; s.exw = 1; s.exrd = 5'd7;
    s.idv = 1; s.idpc = 64'h2000; s.ins = enc_beq(5'd7, 5'd1, 13'h0040);
    go(s, 2'b00, 2'b00, 1, 0, 0, 64'h2004, "R11");

    go(idle(), 2'b00, 2'b00, 0, 0, 0, 64'h2008, "R9");

    @(negedge clk);
    apply(idle());
    repeat (3) @(posedge clk);
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule